// File: doc/BRIEF.md
# Triplicated Output Voting Stage

This block sits at the edge of a triplicated user function. It takes the three redundant copies of a result bus and produces two kinds of output. The first kind is three majority-voted buses, one per redundant domain. Each domain has its own voter, so no single voter can fail all three domains at once. The second kind is three pin drives for a triplicated output whose pins are tied together outside the chip. Each pin has a minority voter. When that pin's own copy of a bit disagrees with the two other copies, which agree with each other, the voter releases that pin bit to high impedance. The external node is then driven only by copies that agree.

Voting and the disagree test are bitwise. Faults in different modules are therefore still masked when they land on different bit positions. Each pin bit has an active-low output enable toward the pad. The same condition is also exported as an active-high disagree flag, so a supervisor can sample which domain and bit position went wrong.

A parameter selects the registered variant. In that variant each domain has a register on its own clock and its own reset. Each register loads the majority of the three module results, so a corrupted copy is rewritten on the next edge of its own clock. The pins, the minority test and the voted outputs then work from the register copies.

Top module: `tmr_out_stage`

## Requirements
- R1: Each voted output bus `votedN_o` equals the bitwise majority of the three module results, where each output bit is 1 when at least two of the three inputs are 1. All three domains give the same value.
- R2: If two or more modules are corrupted, each on a different bit position, every voted bus still equals the uncorrupted value.
- R3: For domain i and bit b, `pin_oe_nI_o[b]` and `disagreeI_o[b]` are 1 exactly when copy i differs from the other two copies at bit b and the other two copies are equal at bit b. Otherwise both are 0. 1 on `pin_oe_n` means released (high impedance) and 0 means driving. In the unregistered variant `pinI_o` equals module result i.
- R4: The pins that are driving a given bit never carry different values at that bit.
- R5: For every bit, at least two of the three pins are driving.
- R6: When `REGISTERED` is 1, each domain's register loads the majority of the three module results on its own clock edge. A single corrupted module therefore never shows up in any register, voted output or pin, and all enables stay at 0.
- R7: When `REGISTERED` is 1, a domain's register changes only on an edge of that domain's own clock. While another domain's clock is stopped, that domain keeps its old value.
- R8: When `REGISTERED` is 1, while a domain's active-low reset `dom_rst_n[d]` is low, its register reads 0. After all domains are reset, all pin enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dom_clk | input | 3 | Per-domain clock; bit d clocks domain d (used when REGISTERED=1) |
| dom_rst_n | input | 3 | Per-domain asynchronous active-low reset |
| mod0_res | input | W | Result bus of redundant module 0 |
| mod1_res | input | W | Result bus of redundant module 1 |
| mod2_res | input | W | Result bus of redundant module 2 |
| voted0_o | output | W | Majority result for domain 0 |
| voted1_o | output | W | Majority result for domain 1 |
| voted2_o | output | W | Majority result for domain 2 |
| pin0_o | output | W | Data toward output pin of domain 0 |
| pin1_o | output | W | Data toward output pin of domain 1 |
| pin2_o | output | W | Data toward output pin of domain 2 |
| pin_oe_n0_o | output | W | Active-low per-bit enable of pin 0 (1 = released) |
| pin_oe_n1_o | output | W | Active-low per-bit enable of pin 1 |
| pin_oe_n2_o | output | W | Active-low per-bit enable of pin 2 |
| disagree0_o | output | W | Per-bit disagree flag of domain 0 |
| disagree1_o | output | W | Per-bit disagree flag of domain 1 |
| disagree2_o | output | W | Per-bit disagree flag of domain 2 |

## Verification
The bench walks a single flipped bit through every bit position of every module. A design that voted on whole words instead of bits, or that wired a rotated voter input to the wrong module, would then pass a corrupted bit to an output or release the wrong pin. Patterns with two or three modules corrupted on different bits target a voter that counted faults per word instead of per bit. Patterns where two modules share the same flip expect the lone honest module to be released, which catches a minority test that ignores whether the other two agree. On the registered copy, the bench stops single domain clocks and expects only the clocked domains to move; a design that shared one clock or one register across domains would update the stopped domain.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
   localparam int unsigned NDOM = 3;

   // index of the domain k steps after domain d, wrapping around the ring
   function automatic int unsigned peer_dom(input int unsigned d, input int unsigned k);
      return (d + k) % NDOM;
   endfunction
endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] y_o
);
   if (W < 1) begin : g_bad_w
      $error("tmr_maj_voter: W must be at least 1");
   end

   assign y_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);

   // any agreeing pair must win its bit position
   always_comb begin
      for (int i = 0; i < W; i++) begin
         p_pair_wins_r1: assert ((a_i[i] != b_i[i] || y_o[i] == a_i[i]) &&
                                 (a_i[i] != c_i[i] || y_o[i] == a_i[i]) &&
                                 (b_i[i] != c_i[i] || y_o[i] == b_i[i]))
            else $error("voter output lost to a minority at bit %0d", i);
      end
   end
endmodule

// File: rtl/tmr_minority_voter.sv
module tmr_minority_voter #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] own_i,
   input  logic [W-1:0] oth_a_i,
   input  logic [W-1:0] oth_b_i,
   output logic [W-1:0] release_o
);
   if (W < 1) begin : g_bad_w
      $error("tmr_minority_voter: W must be at least 1");
   end

   // release a bit only when the two peers agree and this copy is the odd one out
   assign release_o = (own_i ^ oth_a_i) & ~(oth_a_i ^ oth_b_i);

   always_comb begin
      for (int i = 0; i < W; i++) begin
         p_release_cause_r3: assert (!release_o[i] ||
                                     (own_i[i] != oth_a_i[i] && own_i[i] != oth_b_i[i]))
            else $error("pin released at bit %0d without being the minority", i);
      end
   end
endmodule

// File: rtl/tmr_dom_reg.sv
module tmr_dom_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("tmr_dom_reg: W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
   end

   // the copy holds what the domain voter offered at its own previous edge
   p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                 rst_ni |=> q_o == $past(d_i))
      else $error("domain register did not reload its voted input");

   always_comb begin
      p_reset_zero_r8: assert (rst_ni || q_o == '0)
         else $error("domain register nonzero during reset");
   end
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage #(
   parameter int unsigned W          = 8,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic [2:0]   dom_clk,
   input  logic [2:0]   dom_rst_n,
   input  logic [W-1:0] mod0_res,
   input  logic [W-1:0] mod1_res,
   input  logic [W-1:0] mod2_res,
   output logic [W-1:0] voted0_o,
   output logic [W-1:0] voted1_o,
   output logic [W-1:0] voted2_o,
   output logic [W-1:0] pin0_o,
   output logic [W-1:0] pin1_o,
   output logic [W-1:0] pin2_o,
   output logic [W-1:0] pin_oe_n0_o,
   output logic [W-1:0] pin_oe_n1_o,
   output logic [W-1:0] pin_oe_n2_o,
   output logic [W-1:0] disagree0_o,
   output logic [W-1:0] disagree1_o,
   output logic [W-1:0] disagree2_o
);
   import tmr_vote_pkg::*;

   if (W < 1) begin : g_bad_w
      $error("tmr_out_stage: W must be at least 1");
   end
   if (NDOM != 3) begin : g_bad_ndom
      $error("tmr_out_stage: exactly three domains are supported");
   end

   logic [NDOM-1:0][W-1:0] mod_v;
   logic [NDOM-1:0][W-1:0] vote_v;
   logic [NDOM-1:0][W-1:0] stage_v;
   logic [NDOM-1:0][W-1:0] voted_v;
   logic [NDOM-1:0][W-1:0] rel_v;

   assign mod_v[0] = mod0_res;
   assign mod_v[1] = mod1_res;
   assign mod_v[2] = mod2_res;

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      localparam int unsigned NXT = peer_dom(d, 1);
      localparam int unsigned PRV = peer_dom(d, 2);

      tmr_maj_voter #(.W(W)) u_maj (
         .a_i (mod_v[d]),
         .b_i (mod_v[NXT]),
         .c_i (mod_v[PRV]),
         .y_o (vote_v[d])
      );

      if (REGISTERED) begin : g_reg
         tmr_dom_reg #(.W(W)) u_reg (
            .clk_i  (dom_clk[d]),
            .rst_ni (dom_rst_n[d]),
            .d_i    (vote_v[d]),
            .q_o    (stage_v[d])
         );
         assign voted_v[d] = stage_v[d];
      end else begin : g_comb
         assign stage_v[d] = mod_v[d];
         assign voted_v[d] = vote_v[d];
      end

      tmr_minority_voter #(.W(W)) u_min (
         .own_i     (stage_v[d]),
         .oth_a_i   (stage_v[NXT]),
         .oth_b_i   (stage_v[PRV]),
         .release_o (rel_v[d])
      );
   end

   if (!REGISTERED) begin : g_no_clk
      logic unused_clk_rst;
      assign unused_clk_rst = ^{dom_clk, dom_rst_n};
   end

   assign voted0_o    = voted_v[0];
   assign voted1_o    = voted_v[1];
   assign voted2_o    = voted_v[2];
   assign pin0_o      = stage_v[0];
   assign pin1_o      = stage_v[1];
   assign pin2_o      = stage_v[2];
   assign pin_oe_n0_o = rel_v[0];
   assign pin_oe_n1_o = rel_v[1];
   assign pin_oe_n2_o = rel_v[2];
   assign disagree0_o = rel_v[0];
   assign disagree1_o = rel_v[1];
   assign disagree2_o = rel_v[2];

   // shared external node: no two active drivers differ, and a majority always drives
   always_comb begin
      for (int i = 0; i < W; i++) begin
         p_no_fight_r4: assert ((rel_v[0][i] || rel_v[1][i] || stage_v[0][i] == stage_v[1][i]) &&
                                (rel_v[1][i] || rel_v[2][i] || stage_v[1][i] == stage_v[2][i]) &&
                                (rel_v[0][i] || rel_v[2][i] || stage_v[0][i] == stage_v[2][i]))
            else $error("two driving pins disagree at bit %0d", i);
         p_two_drive_r5: assert ($countones(~{rel_v[0][i], rel_v[1][i], rel_v[2][i]}) >= 2)
            else $error("fewer than two pins drive bit %0d", i);
      end
   end
endmodule

// File: tb/tmr_out_stage_tb_top.sv
module tmr_out_stage_tb_top;
   localparam int unsigned W = 8;

   typedef struct {
      logic [W-1:0] m [3];
      logic [W-1:0] vote;
      logic [W-1:0] oe [3];
      logic [W-1:0] rq [3];
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic [2:0]   clk_en = 3'b111;
   logic [2:0]   rst_n = 3'b000;
   logic [2:0]   dclk;
   logic [W-1:0] m0 = '0, m1 = '0, m2 = '0;

   logic [W-1:0] v0, v1, v2, p0, p1, p2, oe0, oe1, oe2, f0, f1, f2;
   logic [W-1:0] rv0, rv1, rv2, rp0, rp1, rp2, roe0, roe1, roe2, rf0, rf1, rf2;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   item_t sb_q[$];
   logic [W-1:0] model_q [3];

   always #10 clk = ~clk;
   assign dclk = {3{clk}} & clk_en;

   tmr_out_stage #(.W(W), .REGISTERED(1'b0)) dut_i (
      .dom_clk(dclk), .dom_rst_n(rst_n),
      .mod0_res(m0), .mod1_res(m1), .mod2_res(m2),
      .voted0_o(v0), .voted1_o(v1), .voted2_o(v2),
      .pin0_o(p0), .pin1_o(p1), .pin2_o(p2),
      .pin_oe_n0_o(oe0), .pin_oe_n1_o(oe1), .pin_oe_n2_o(oe2),
      .disagree0_o(f0), .disagree1_o(f1), .disagree2_o(f2)
   );

   tmr_out_stage #(.W(W), .REGISTERED(1'b1)) dut_reg_i (
      .dom_clk(dclk), .dom_rst_n(rst_n),
      .mod0_res(m0), .mod1_res(m1), .mod2_res(m2),
      .voted0_o(rv0), .voted1_o(rv1), .voted2_o(rv2),
      .pin0_o(rp0), .pin1_o(rp1), .pin2_o(rp2),
      .pin_oe_n0_o(roe0), .pin_oe_n1_o(roe1), .pin_oe_n2_o(roe2),
      .disagree0_o(rf0), .disagree1_o(rf1), .disagree2_o(rf2)
   );

   task automatic chk(input string req, input string what, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] maj(input logic [W-1:0] a, b, c);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
      return r;
   endfunction

   // driver: applies one pattern at a falling edge and queues what must follow
   task automatic drive(input logic [W-1:0] a, b, c, input logic [2:0] en, input string tag);
      item_t it;
      @(negedge clk);
      m0 = a; m1 = b; m2 = c; clk_en = en;
      it.m[0] = a; it.m[1] = b; it.m[2] = c;
      it.vote = maj(a, b, c);
      for (int d = 0; d < 3; d++) begin
         logic [W-1:0] own, oa, ob;
         own = it.m[d]; oa = it.m[(d + 1) % 3]; ob = it.m[(d + 2) % 3];
         for (int i = 0; i < W; i++)
            it.oe[d][i] = (own[i] != oa[i]) && (oa[i] == ob[i]);
         if (en[d]) model_q[d] = it.vote;
         it.rq[d] = model_q[d];
      end
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // monitor: samples halfway between the capturing edge and the next drive
   initial begin
      item_t it;
      logic [W-1:0] va [3], pa [3], oa [3], fa [3], rva [3], rpa [3], roa [3];
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() != 0) begin
            it = sb_q.pop_front();
            va  = '{v0, v1, v2};    pa  = '{p0, p1, p2};
            oa  = '{oe0, oe1, oe2}; fa  = '{f0, f1, f2};
            rva = '{rv0, rv1, rv2}; rpa = '{rp0, rp1, rp2};
            roa = '{roe0, roe1, roe2};
            for (int d = 0; d < 3; d++) begin
               chk(it.tag, $sformatf("voted dom%0d", d), va[d], it.vote);
               chk("R3", $sformatf("pin data dom%0d", d), pa[d], it.m[d]);
               chk("R3", $sformatf("oe_n dom%0d", d), oa[d], it.oe[d]);
               chk("R3", $sformatf("disagree dom%0d", d), fa[d], it.oe[d]);
               chk(it.tag == "R7" ? "R7" : "R6", $sformatf("reg voted dom%0d", d), rva[d], it.rq[d]);
               chk("R6", $sformatf("reg pin dom%0d", d), rpa[d], it.rq[d]);
            end
            if (it.tag != "R7")
               chk("R6", "reg oe_n all", roa[0] | roa[1] | roa[2], '0);
            begin
               logic [W-1:0] fight, few;
               fight = '0; few = '0;
               for (int i = 0; i < W; i++) begin
                  int n1, n0;
                  n1 = 0; n0 = 0;
                  for (int d = 0; d < 3; d++)
                     if (!oa[d][i]) begin
                        if (pa[d][i]) n1++; else n0++;
                     end
                  fight[i] = (n1 > 0) && (n0 > 0);
                  few[i]   = (n1 + n0) < 2;
               end
               chk("R4", "external node contention bits", fight, '0);
               chk("R5", "bits with under two drivers", few, '0);
            end
         end
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] base;
      for (int d = 0; d < 3; d++) model_q[d] = '0;
      repeat (3) @(negedge clk);
      // R8: reset holds every register copy at zero with all pins driving
      chk("R8", "reg voted0 in reset", rv0, '0);
      chk("R8", "reg voted1 in reset", rv1, '0);
      chk("R8", "reg voted2 in reset", rv2, '0);
      chk("R8", "reg oe_n in reset", roe0 | roe1 | roe2, '0);
      rst_n = 3'b111;

      drive(8'h00, 8'h00, 8'h00, 3'b111, "R1");
      drive(8'hFF, 8'hFF, 8'hFF, 3'b111, "R1");
      drive(8'hA5, 8'hA5, 8'hA5, 3'b111, "R1");

      // every single-bit corruption of every module
      base = 8'h3C;
      for (int m = 0; m < 3; m++)
         for (int b = 0; b < W; b++) begin
            logic [W-1:0] v [3];
            v = '{base, base, base};
            v[m] = base ^ (W'(1) << b);
            drive(v[0], v[1], v[2], 3'b111, "R1");
         end

      // R2: several modules hit, each on distinct bits
      drive(8'h3C ^ 8'h01, 8'h3C ^ 8'h08, 8'h3C ^ 8'h80, 3'b111, "R2");
      drive(8'h96 ^ 8'h0F, 8'h96 ^ 8'hF0, 8'h96, 3'b111, "R2");
      drive(8'h5A ^ 8'h24, 8'h5A ^ 8'h42, 8'h5A ^ 8'h81, 3'b111, "R2");

      // R3: two modules share a flip, the lone honest copy becomes minority
      drive(8'h70 ^ 8'h04, 8'h70 ^ 8'h04, 8'h70, 3'b111, "R1");
      drive(8'hC3, 8'hC3 ^ 8'h10, 8'hC3 ^ 8'h10, 3'b111, "R1");

      // R7: stop individual domain clocks, only clocked domains reload
      drive(8'h11, 8'h11, 8'h11, 3'b010, "R7");
      drive(8'h22, 8'h22, 8'h22, 3'b101, "R7");
      drive(8'h33, 8'h33, 8'h33, 3'b100, "R7");
      drive(8'h44, 8'h44, 8'h44, 3'b111, "R6");

      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule